// File: doc/BRIEF.md
# Rename Map with Early-Release Marking

This block is the dispatch-stage rename map of an out-of-order core. It maps each logical register to a physical register. Each logical register also carries a flag saying that its value is read exactly once, so the physical register may be freed as soon as that single reader issues. For each dispatched instruction, the block looks up the physical tags of both sources and the flag of each source. It allocates a fresh destination tag from an external free list and reports the tag that the destination displaced. All of these are presented, one cycle later, as the fields of a new reorder-buffer entry.

A configuration instruction carries a count N and reprograms the flags: the N highest-numbered non-zero logical registers become early-release, and all others become ordinary multi-use registers. A count of zero turns the scheme off, for example before entering code that was not prepared for it. The rename logic guarantees that an instruction naming the same logical register twice produces at most one flag. It never flags the hardwired zero register. Dispatch stalls when a destination is needed and the free list is empty.

Top module: `rename_er_map`

## Requirements
- R1: After reset, logical register i maps to physical tag i, no logical register is flagged early-release, and rob_valid is low.
- R2: In the cycle after an instruction dispatches, rob_src0_tag and rob_src1_tag carry the current mappings of its sources. When the instruction writes a destination, rob_dst_tag equals the fl_tag that was popped and rob_old_tag equals the tag the destination held before. Later instructions then read the new mapping. When no tag is allocated, rob_dst_tag and rob_old_tag are 0.
- R3: rob_src0_er and rob_src1_er carry the early-release flag that the map holds for each source at dispatch.
- R4: When both sources name the same logical register, rob_src1_er is 0 and rob_src0_er keeps the register's flag.
- R5: A configuration instruction with count N flags the logical registers 30, 29, …, 31-N (the N highest indices below the zero register 31) and clears every other flag. A count of 31 flags registers 0 to 30.
- R6: A configuration instruction with count 0 clears every flag.
- R7: A configuration instruction produces no reorder-buffer entry (rob_valid stays low) and pops no tag. Its new flags apply from the next dispatched instruction onward.
- R8: When disp_has_dst is set, the destination is not register 31, and fl_valid is low, disp_ready is low, nothing is popped, and the mapping is left unchanged.
- R9: Logical register 31 is never reported as early-release. A destination of 31 allocates no tag, and rob_has_dst is 0 for it.
- R10: While disp_valid is low, no mapping or flag changes and rob_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_is_cfg | input | 1 | The offered instruction is the flag configuration no-op |
| disp_cfg_count | input | 5 | Number of early-release registers for a configuration instruction |
| disp_src0 | input | 5 | First source logical register |
| disp_src1 | input | 5 | Second source logical register |
| disp_dst | input | 5 | Destination logical register |
| disp_has_dst | input | 1 | Instruction writes disp_dst |
| fl_valid | input | 1 | The free list holds a tag |
| fl_tag | input | 6 | Tag at the head of the free list |
| disp_ready | output | 1 | The offered instruction can dispatch this cycle |
| fl_pop | output | 1 | The head free-list tag is consumed this cycle |
| rob_valid | output | 1 | The entry fields below describe a newly dispatched instruction |
| rob_has_dst | output | 1 | The entry allocated a destination tag |
| rob_src0_tag | output | 6 | Physical tag of the first source |
| rob_src0_er | output | 1 | Early-release flag of the first source |
| rob_src1_tag | output | 6 | Physical tag of the second source |
| rob_src1_er | output | 1 | Early-release flag of the second source |
| rob_dst_tag | output | 6 | Newly allocated destination tag |
| rob_old_tag | output | 6 | Tag the destination mapped to before this instruction |

## Verification
Renames are first driven with plain distinct sources, then with a source that reads a just-written destination. This separates a map that forwards new tags from one that keeps the reset identity. Flag patterns are driven with counts of 5, 1, 31 and 0, reading registers just inside and just outside the flagged span, which shows whether the span starts at the correct end and has the correct length. Repeated-source, zero-register, empty-free-list and idle-cycle patterns separate correct suppression from a flag or write that leaks through. A second reset after the flags and the map were changed shows that both return to their initial state.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  localparam int unsigned LREGS  = 32;
  localparam int unsigned PREGS  = 64;
  localparam int unsigned LREG_W = $clog2(LREGS);
  localparam int unsigned PREG_W = $clog2(PREGS);
  localparam int unsigned CNT_W  = LREG_W;
  localparam int unsigned ZERO_IDX = LREGS - 1;

  typedef logic [LREG_W-1:0] lreg_t;
  typedef logic [PREG_W-1:0] preg_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    preg_t tag;
    logic  er;
  } src_info_t;
endpackage

// File: rtl/rmap_er_flags.sv
module rmap_er_flags
  import rmap_pkg::*;
#(
  parameter bit HAS_ZERO = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  cnt_t             cfg_cnt,
  output logic [LREGS-1:0] er_vec
);
  localparam int TOP = HAS_ZERO ? int'(LREGS) - 2 : int'(LREGS) - 1;

  logic [LREGS-1:0] er_q, er_d;

  always_comb begin
    er_d = er_q;
    if (cfg_we) begin
      for (int i = 0; i < int'(LREGS); i++) begin
        er_d[i] = (i <= TOP) && ((TOP - i) < int'(cfg_cnt));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) er_q <= '0;
    else        er_q <= er_d;
  end

  assign er_vec = er_q;

  // R6: a zero count leaves no register flagged
  a_r6_zero_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_cnt == '0) |=> (er_q == '0));

  // R10: flags move only through a configuration write
  a_r10_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(er_q));
endmodule

// File: rtl/rmap_table.sv
module rmap_table
  import rmap_pkg::*;
#(
  parameter int unsigned RD_PORTS = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  lreg_t waddr,
  input  preg_t wdata,
  input  lreg_t raddr [RD_PORTS],
  output preg_t rdata [RD_PORTS]
);
  preg_t map_q [LREGS];
  preg_t map_d [LREGS];

  always_comb begin
    for (int i = 0; i < int'(LREGS); i++) begin
      map_d[i] = map_q[i];
    end
    if (we) map_d[waddr] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(LREGS); i++) map_q[i] <= preg_t'(i);
    end else begin
      for (int i = 0; i < int'(LREGS); i++) map_q[i] <= map_d[i];
    end
  end

  for (genvar p = 0; p < int'(RD_PORTS); p++) begin : g_rd
    assign rdata[p] = map_q[raddr[p]];
  end

  // R2: a write lands at its address
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (map_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/rmap_src_port.sv
module rmap_src_port
  import rmap_pkg::*;
#(
  parameter bit HAS_ZERO = 1'b1
) (
  input  lreg_t     lidx,
  input  preg_t     ptag,
  input  logic      er_bit,
  input  logic      kill,
  output src_info_t info
);
  logic is_zero;
  assign is_zero  = HAS_ZERO && (lidx == lreg_t'(ZERO_IDX));
  assign info.tag = ptag;
  assign info.er  = er_bit && !is_zero && !kill;
endmodule

// File: rtl/rename_er_map.sv
module rename_er_map
  import rmap_pkg::*;
#(
  parameter bit HAS_ZERO_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disp_valid,
  input  logic              disp_is_cfg,
  input  logic [CNT_W-1:0]  disp_cfg_count,
  input  logic [LREG_W-1:0] disp_src0,
  input  logic [LREG_W-1:0] disp_src1,
  input  logic [LREG_W-1:0] disp_dst,
  input  logic              disp_has_dst,
  input  logic              fl_valid,
  input  logic [PREG_W-1:0] fl_tag,
  output logic              disp_ready,
  output logic              fl_pop,
  output logic              rob_valid,
  output logic              rob_has_dst,
  output logic [PREG_W-1:0] rob_src0_tag,
  output logic              rob_src0_er,
  output logic [PREG_W-1:0] rob_src1_tag,
  output logic              rob_src1_er,
  output logic [PREG_W-1:0] rob_dst_tag,
  output logic [PREG_W-1:0] rob_old_tag
);
  localparam int unsigned NSRC = 2;
  localparam int unsigned NRD  = NSRC + 1;

  logic             dst_is_zero, need_dst, fire, cfg_we, dup_src;
  logic [LREGS-1:0] er_vec;
  lreg_t            raddr [NRD];
  preg_t            rdata [NRD];
  lreg_t            src_idx [NSRC];
  src_info_t        src_info [NSRC];

  assign dst_is_zero = HAS_ZERO_REG && (disp_dst == lreg_t'(ZERO_IDX));
  assign need_dst    = disp_has_dst && !disp_is_cfg && !dst_is_zero;
  assign disp_ready  = !(need_dst && !fl_valid);
  assign fire        = disp_valid && disp_ready;
  assign fl_pop      = fire && need_dst;
  assign cfg_we      = fire && disp_is_cfg;
  assign dup_src     = (disp_src0 == disp_src1);

  assign src_idx[0] = disp_src0;
  assign src_idx[1] = disp_src1;
  assign raddr[0]   = disp_src0;
  assign raddr[1]   = disp_src1;
  assign raddr[2]   = disp_dst;

  rmap_er_flags #(.HAS_ZERO(HAS_ZERO_REG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_cnt (disp_cfg_count),
    .er_vec  (er_vec)
  );

  rmap_table #(.RD_PORTS(NRD)) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fl_pop),
    .waddr (disp_dst),
    .wdata (fl_tag),
    .raddr (raddr),
    .rdata (rdata)
  );

  // the second port of a repeated source drops its flag
  for (genvar s = 0; s < int'(NSRC); s++) begin : g_src
    rmap_src_port #(.HAS_ZERO(HAS_ZERO_REG)) u_port (
      .lidx   (src_idx[s]),
      .ptag   (rdata[s]),
      .er_bit (er_vec[src_idx[s]]),
      .kill   ((s != 0) && dup_src),
      .info   (src_info[s])
    );
  end

  // entry register: next state, then flops with an explicit enable
  logic        valid_d, cap_en, hd_d;
  src_info_t   s0_d, s1_d;
  preg_t       dt_d, ot_d;
  src_info_t   s0_q, s1_q;

  assign valid_d = fire && !disp_is_cfg;
  assign cap_en  = valid_d;
  assign hd_d    = fl_pop;
  assign s0_d    = src_info[0];
  assign s1_d    = src_info[1];
  assign dt_d    = fl_pop ? fl_tag   : '0;
  assign ot_d    = fl_pop ? rdata[2] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rob_valid <= 1'b0;
    else        rob_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rob_has_dst <= 1'b0;
      s0_q        <= '0;
      s1_q        <= '0;
      rob_dst_tag <= '0;
      rob_old_tag <= '0;
    end else if (cap_en) begin
      rob_has_dst <= hd_d;
      s0_q        <= s0_d;
      s1_q        <= s1_d;
      rob_dst_tag <= dt_d;
      rob_old_tag <= ot_d;
    end
  end

  assign rob_src0_tag = s0_q.tag;
  assign rob_src0_er  = s0_q.er;
  assign rob_src1_tag = s1_q.tag;
  assign rob_src1_er  = s1_q.er;

  // R4: repeated source yields at most one flag
  a_r4_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !disp_is_cfg && dup_src) |=> !(rob_src0_er && rob_src1_er));

  // R7: configuration makes no entry and pops nothing
  a_r7_cfg_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && disp_is_cfg) |=> !rob_valid);
  a_r7_cfg_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_is_cfg) |-> !fl_pop);

  // R8: a pop needs a tag
  a_r8_pop_has_tag: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pop |-> fl_valid);

  // R9: zero register never flagged
  a_r9_zero_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !disp_is_cfg && HAS_ZERO_REG && disp_src0 == lreg_t'(ZERO_IDX))
      |=> !rob_src0_er);

  // R10: no entry without dispatch
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_valid |=> !rob_valid);
endmodule

// File: tb/rename_er_map_tb.sv
module rename_er_map_tb;
  logic       clk, rst_n;
  logic       disp_valid, disp_is_cfg, disp_has_dst, fl_valid;
  logic [4:0] disp_cfg_count, disp_src0, disp_src1, disp_dst;
  logic [5:0] fl_tag;
  logic       disp_ready, fl_pop, rob_valid, rob_has_dst, rob_src0_er, rob_src1_er;
  logic [5:0] rob_src0_tag, rob_src1_tag, rob_dst_tag, rob_old_tag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  rename_er_map u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  typedef struct packed {
    logic vld, cfg; logic [4:0] cnt, s0, s1, d; logic hd, fv; logic [5:0] ft;
    logic rdy, pop, ov, ohd; logic [5:0] t0, t1; logic e0, e1;
    logic [5:0] dt, od; logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1,0, 0,  1, 2, 3,1,1,40, 1,1,1,1,  1, 2,0,0,40, 3, 2}, // R2 plain
    '{1,0, 0,  3, 3, 4,1,1,41, 1,1,1,1, 40,40,0,0,41, 4, 2}, // R2 reads new map
    '{1,1, 5,  0, 0, 0,0,0, 0, 1,0,0,0,  0, 0,0,0, 0, 0, 7}, // R7 cfg 5
    '{1,0, 0, 30,26, 5,1,1,42, 1,1,1,1, 30,26,1,1,42, 5, 3}, // R3 span edges
    '{1,0, 0, 28,28, 6,1,1,43, 1,1,1,1, 28,28,1,0,43, 6, 4}, // R4 duplicate
    '{1,0, 0, 25,31,27,1,1,44, 1,1,1,1, 25,31,0,0,44,27, 5}, // R5 outside span
    '{1,0, 0, 27, 3, 0,0,1,50, 1,0,1,0, 44,40,1,0, 0, 0, 3}, // R3 renamed ER reg
    '{1,0, 0,  1, 2, 7,1,0, 0, 0,0,0,0,  0, 0,0,0, 0, 0, 8}, // R8 stall
    '{1,0, 0,  7, 7, 7,1,1,45, 1,1,1,1,  7, 7,0,0,45, 7, 8}, // R8 map untouched
    '{1,0, 0,  1, 2,31,1,1,46, 1,0,1,0,  1, 2,0,0, 0, 0, 9}, // R9 zero dst
    '{1,0, 0, 30,31, 0,0,0, 0, 1,0,1,0, 30,31,1,0, 0, 0, 7}, // R7 before cfg
    '{1,1, 0,  0, 0, 0,0,0, 0, 1,0,0,0,  0, 0,0,0, 0, 0, 6}, // R6 cfg 0
    '{1,0, 0, 30,28, 8,1,1,47, 1,1,1,1, 30,28,0,0,47, 8, 6}, // R6 cleared
    '{1,1,31,  0, 0, 0,0,0, 0, 1,0,0,0,  0, 0,0,0, 0, 0, 5}, // R5 cfg 31
    '{1,0, 0,  0,31, 0,0,0, 0, 1,0,1,0,  0,31,1,0, 0, 0, 9}, // R9 zero src
    '{0,1, 0,  0, 0, 0,0,0, 0, 1,0,0,0,  0, 0,0,0, 0, 0,10}, // R10 idle cfg
    '{1,0, 0,  0, 1, 0,0,0, 0, 1,0,1,0,  0, 1,1,1, 0, 0,10}, // R10 flags kept
    '{1,1, 1,  0, 0, 0,0,0, 0, 1,0,0,0,  0, 0,0,0, 0, 0, 5}, // R5 cfg 1
    '{1,0, 0, 30,29, 0,0,0, 0, 1,0,1,0, 30,29,1,0, 0, 0, 5}  // R5 single
  };

  task automatic chk(input string what, input int req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    disp_valid = 0; disp_is_cfg = 0; disp_cfg_count = 0;
    disp_src0 = 0; disp_src1 = 0; disp_dst = 0; disp_has_dst = 0;
    fl_valid = 0; fl_tag = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    drive_idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("reset rob_valid", 1, rob_valid, 0);
    chk("reset ready", 1, disp_ready, 1);

    for (int k = 0; k < NV; k++) begin
      disp_valid = VECS[k].vld; disp_is_cfg = VECS[k].cfg;
      disp_cfg_count = VECS[k].cnt; disp_src0 = VECS[k].s0; disp_src1 = VECS[k].s1;
      disp_dst = VECS[k].d; disp_has_dst = VECS[k].hd;
      fl_valid = VECS[k].fv; fl_tag = VECS[k].ft;
      #1;
      chk($sformatf("v%0d ready", k), VECS[k].req, disp_ready, VECS[k].rdy);
      chk($sformatf("v%0d pop", k), VECS[k].req, fl_pop, VECS[k].pop);
      @(negedge clk);
      chk($sformatf("v%0d rob_valid", k), VECS[k].req, rob_valid, VECS[k].ov);
      if (VECS[k].ov) begin
        chk($sformatf("v%0d has_dst", k), VECS[k].req, rob_has_dst, VECS[k].ohd);
        chk($sformatf("v%0d src0_tag", k), VECS[k].req, rob_src0_tag, VECS[k].t0);
        chk($sformatf("v%0d src1_tag", k), VECS[k].req, rob_src1_tag, VECS[k].t1);
        chk($sformatf("v%0d src0_er", k), VECS[k].req, rob_src0_er, VECS[k].e0);
        chk($sformatf("v%0d src1_er", k), VECS[k].req, rob_src1_er, VECS[k].e1);
        chk($sformatf("v%0d dst_tag", k), VECS[k].req, rob_dst_tag, VECS[k].dt);
        chk($sformatf("v%0d old_tag", k), VECS[k].req, rob_old_tag, VECS[k].od);
      end
    end

    // R1: second reset restores identity map and clears flags
    drive_idle();
    rst_n = 0;
    @(negedge clk);
    chk("reset again rob_valid", 1, rob_valid, 0);
    rst_n = 1;
    @(negedge clk);
    disp_valid = 1; disp_src0 = 3; disp_src1 = 30; disp_dst = 27; disp_has_dst = 1;
    fl_valid = 1; fl_tag = 55;
    @(negedge clk);
    drive_idle();
    chk("r1_ identity src0", 1, rob_src0_tag, 3);
    chk("r1_ identity src1", 1, rob_src1_tag, 30);
    chk("r1_ flag cleared", 1, rob_src1_er, 0);
    chk("r1_ identity old", 1, rob_old_tag, 27);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule